// File: doc/BRIEF.md
# Priority Interrupt Acceptance Unit

This unit sits between fifteen interrupt request lines and a pipelined integer unit. Each line stands for one priority level, from 1 (lowest) to 15 (highest). A rising edge on a line sets a sticky pending bit for that level. A priority encoder picks the highest pending level. At an instruction boundary the unit decides whether the processor may take that interrupt now.

It accepts the interrupt only when all of these hold:
- traps are enabled;
- no synchronous trap is waiting, because a synchronous trap always goes first;
- the level is strictly above the processor's current interrupt level, except that level 15 passes this test whenever traps are enabled.

On acceptance the unit gives a one-cycle take strobe, together with the level and the trap-type code that the processor writes into its trap base register. The pending bit of the serviced level is cleared on the same clock edge that raises the strobe.

The control is a three-state machine, with a state register process and a separate output process:
- `ST_IDLE`: nothing is pending.
- `ST_HOLD`: something is pending but has not been taken.
- `ST_TAKE`: the strobe cycle.

Transitions:
- `IDLE→HOLD` on any pending bit.
- `HOLD→IDLE` when the pending set is empty.
- `IDLE/HOLD→TAKE` on a grant.
- `TAKE→HOLD` or `TAKE→IDLE`, depending on whether anything is still pending.

No grant can be made from `ST_TAKE`.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset `take_irq`, `irq_level` and `trap_type` are all 0, and no level is pending.
- R2: A 0→1 transition on `irq_req[n-1]` marks level n pending, and the bit stays set after the line falls. A pending level can be accepted at the clock edge after the one that captured the edge.
- R3: A request line held high produces only one acceptance. It must fall and rise again to request again.
- R4: When several levels are pending, the highest numbered level is accepted first.
- R5: No interrupt is accepted while `trap_en` is 0. Pending requests are kept and are taken once `trap_en` is 1.
- R6: A level below 15 is accepted only if it is strictly greater than `proc_pil`. A level equal to or below `proc_pil` waits.
- R7: Level 15 is accepted whenever `trap_en` is 1, even when `proc_pil` is 15.
- R8: While `sync_trap_pend` is 1 no interrupt is accepted. The request stays pending.
- R9: Acceptance is decided only at a clock edge where `insn_bound` is 1. `take_irq` is high in the cycle after that edge.
- R10: During the strobe, `irq_level` is n and `trap_type` is 8'h10 + n. Both are 0 when `take_irq` is 0.
- R11: `take_irq` lasts exactly one cycle and is never high in two adjacent cycles. The serviced pending bit is cleared, so the next lower pending level is taken at a following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 15 | Request lines; bit n-1 carries level n |
| trap_en | input | 1 | Trap-enable bit of the processor status |
| proc_pil | input | 4 | Current processor interrupt level |
| sync_trap_pend | input | 1 | A synchronous trap is waiting |
| insn_bound | input | 1 | Instruction-fetch boundary strobe |
| take_irq | output | 1 | One-cycle acceptance strobe |
| trap_type | output | 8 | Trap-type code 8'h10 + level during the strobe |
| irq_level | output | 4 | Accepted level during the strobe |

## Verification
The bench uses several kinds of request pattern:
- **Single pulsed requests** show that an edge is captured and held.
- **Simultaneous requests on two levels** show the priority order and that the serviced bit is cleared.
- **A line held high for many cycles** separates edge capture from level sensing.

Each gating input is in turn held against a pending request and then released. This covers `trap_en` low, `proc_pil` equal to and above the level, level 15 at `proc_pil` 15, a pending synchronous trap, and `insn_bound` low. In each case the bench shows that the request was deferred, not lost. A behavioural model compares all three outputs on every clock throughout.

// File: rtl/iau_pkg.sv
package iau_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_TAKE
    } iau_state_e;

    localparam logic [7:0] IRQ_TT_BASE = 8'h10;
endpackage

// File: rtl/iau_pending.sv
// Edge capture and sticky pending bits, one per level.
module iau_pending #(
    parameter int NLVL = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] req_i,
    input  logic [NLVL-1:0] clr_i,
    output logic [NLVL-1:0] pend_o
);
    logic [NLVL-1:0] req_q;

    for (genvar g = 0; g < NLVL; g++) begin : g_bit
        logic rise;
        assign rise = req_i[g] & ~req_q[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[g]  <= 1'b0;
                pend_o[g] <= 1'b0;
            end else begin
                req_q[g]  <= req_i[g];
                // A fresh edge wins over a clear in the same cycle.
                pend_o[g] <= (pend_o[g] & ~clr_i[g]) | rise;
            end
        end
    end
endmodule

// File: rtl/iau_prio.sv
// Highest-set-bit encoder; bit g stands for level g+1.
module iau_prio #(
    parameter int NLVL = 15,
    parameter int LW   = 4
) (
    input  logic [NLVL-1:0] pend_i,
    output logic [LW-1:0]   lvl_o
);
    logic [NLVL-1:0] above;
    logic [NLVL-1:0] sel;

    for (genvar g = 0; g < NLVL; g++) begin : g_chain
        if (g == NLVL - 1) begin : g_top
            assign above[g] = 1'b0;
        end else begin : g_mid
            assign above[g] = above[g+1] | pend_i[g+1];
        end
        assign sel[g] = pend_i[g] & ~above[g];
    end

    always_comb begin
        lvl_o = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (sel[i]) lvl_o = lvl_o | LW'(i + 1);
        end
    end
endmodule

// File: rtl/iau_fsm.sv
// Acceptance state machine.
module iau_fsm #(
    parameter int NLVL = 15,
    parameter int LW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_pend_i,
    input  logic [LW-1:0] hi_lvl_i,
    input  logic          trap_en_i,
    input  logic [LW-1:0] pil_i,
    input  logic          sync_i,
    input  logic          bound_i,
    output logic          grant_o,
    output logic          take_o,
    output logic [LW-1:0] lvl_o
);
    import iau_pkg::*;

    localparam logic [LW-1:0] NMI_LVL = LW'(NLVL);

    iau_state_e    state_q, state_d;
    logic [LW-1:0] lvl_q;
    logic          above_pil;

    assign above_pil = (hi_lvl_i > pil_i) || (hi_lvl_i == NMI_LVL);

    always_comb begin
        grant_o = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HOLD: begin
                if (any_pend_i && bound_i && trap_en_i && !sync_i && above_pil) begin
                    grant_o = 1'b1;
                    state_d = ST_TAKE;
                end else if (any_pend_i) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_TAKE: begin
                state_d = any_pend_i ? ST_HOLD : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= grant_o ? hi_lvl_i : '0;
        end
    end

    // Output process.
    always_comb begin
        take_o = (state_q == ST_TAKE);
        lvl_o  = take_o ? lvl_q : '0;
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
    parameter int NLVL = 15,
    parameter int LW   = $clog2(NLVL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] irq_req,
    input  logic            trap_en,
    input  logic [LW-1:0]   proc_pil,
    input  logic            sync_trap_pend,
    input  logic            insn_bound,
    output logic            take_irq,
    output logic [7:0]      trap_type,
    output logic [LW-1:0]   irq_level
);
    import iau_pkg::*;

    logic [NLVL-1:0] pend;
    logic [NLVL-1:0] clr;
    logic [LW-1:0]   hi_lvl;
    logic            grant;

    iau_pending #(.NLVL(NLVL)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req),
        .clr_i  (clr),
        .pend_o (pend)
    );

    iau_prio #(.NLVL(NLVL), .LW(LW)) u_prio (
        .pend_i (pend),
        .lvl_o  (hi_lvl)
    );

    iau_fsm #(.NLVL(NLVL), .LW(LW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_pend_i (|pend),
        .hi_lvl_i   (hi_lvl),
        .trap_en_i  (trap_en),
        .pil_i      (proc_pil),
        .sync_i     (sync_trap_pend),
        .bound_i    (insn_bound),
        .grant_o    (grant),
        .take_o     (take_irq),
        .lvl_o      (irq_level)
    );

    // Clear only the level being granted.
    for (genvar g = 0; g < NLVL; g++) begin : g_clr
        assign clr[g] = grant && (hi_lvl == LW'(g + 1));
    end

    assign trap_type = take_irq ? (IRQ_TT_BASE + 8'(irq_level)) : 8'h00;
endmodule

// File: rtl/iau_chk.sv
module iau_chk #(
    parameter int NLVL = 15,
    parameter int LW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trap_en,
    input logic [LW-1:0] proc_pil,
    input logic          sync_trap_pend,
    input logic          insn_bound,
    input logic          take_irq,
    input logic [7:0]    trap_type,
    input logic [LW-1:0] irq_level
);
    localparam logic [LW-1:0] NMI_LVL = LW'(NLVL);

    // R11
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq);

    // R9
    bound_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_irq) |-> $past(insn_bound));

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_irq) |-> $past(trap_en));

    // R8
    sync_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_irq) |-> !$past(sync_trap_pend));

    // R6
    pil_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_irq) |-> (irq_level > $past(proc_pil) || irq_level == NMI_LVL));

    // R10
    code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_irq |-> (irq_level == '0 && trap_type == 8'h00));

    // R10
    code_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (irq_level != '0 && trap_type[7:4] == 4'h1));
endmodule

bind irq_accept_unit iau_chk #(.NLVL(NLVL), .LW(LW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_en        (trap_en),
    .proc_pil       (proc_pil),
    .sync_trap_pend (sync_trap_pend),
    .insn_bound     (insn_bound),
    .take_irq       (take_irq),
    .trap_type      (trap_type),
    .irq_level      (irq_level)
);

// File: tb/sim_irq_accept_unit.sv
`timescale 1ns/1ps
module sim_irq_accept_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] irq_req = '0;
    logic        trap_en = 1'b0;
    logic [3:0]  proc_pil = '0;
    logic        sync_trap_pend = 1'b0;
    logic        insn_bound = 1'b0;
    logic        take_irq;
    logic [7:0]  trap_type;
    logic [3:0]  irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_accept_unit u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trap_en(trap_en),
        .proc_pil(proc_pil), .sync_trap_pend(sync_trap_pend),
        .insn_bound(insn_bound), .take_irq(take_irq),
        .trap_type(trap_type), .irq_level(irq_level)
    );

    // Behavioural reference model
    bit m_pend[16];
    bit m_prev[16];
    bit m_take;
    int m_lvl;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < 16; l++) begin m_pend[l] = 0; m_prev[l] = 0; end
            m_take = 0; m_lvl = 0;
        end else begin
            int hi;
            bit g;
            hi = 0;
            for (int l = 15; l >= 1; l--) if (m_pend[l] && hi == 0) hi = l;
            g = !m_take && insn_bound && trap_en && !sync_trap_pend && hi != 0
                && (hi > int'(proc_pil) || hi == 15);
            if (g) m_pend[hi] = 0;
            for (int l = 1; l <= 15; l++) begin
                if (irq_req[l-1] && !m_prev[l]) m_pend[l] = 1;
                m_prev[l] = irq_req[l-1];
            end
            m_take = g;
            m_lvl = g ? hi : 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(take_irq == m_take, "R11 model take", int'(take_irq), int'(m_take));
            check(int'(irq_level) == m_lvl, "R10 model level", int'(irq_level), m_lvl);
            check(int'(trap_type) == (m_take ? 16 + m_lvl : 0), "R10 model type",
                  int'(trap_type), m_take ? 16 + m_lvl : 0);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic pulse(input int lvl);
        irq_req[lvl-1] = 1'b1; step(); irq_req[lvl-1] = 1'b0;
    endtask

    task automatic expect_take(input int lvl, input string tag);
        check(take_irq == 1'b1 && int'(irq_level) == lvl && int'(trap_type) == 16 + lvl,
              tag, int'(irq_level), lvl);
    endtask

    task automatic expect_none(input string tag);
        check(take_irq == 1'b0, tag, int'(take_irq), 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check(take_irq == 0 && irq_level == 0 && trap_type == 0, "R1 reset outputs",
              int'(trap_type), 0);

        // R2 edge capture, R10 code
        trap_en = 1; proc_pil = 0; insn_bound = 1;
        pulse(5); step();
        expect_take(5, "R2 R10 single level 5");
        step(); expect_none("R11 no second strobe");

        // R9 boundary gating, R4 priority, R11 clear
        insn_bound = 0;
        irq_req[2] = 1; irq_req[8] = 1; step(); irq_req[2] = 0; irq_req[8] = 0;
        step(); step(); expect_none("R9 no boundary");
        insn_bound = 1; step(); expect_take(9, "R4 highest first");
        step(); expect_none("R11 gap after strobe");
        step(); expect_take(3, "R11 lower next");
        step();

        // R5 trap enable
        trap_en = 0; pulse(7); step(); step(); expect_none("R5 traps disabled");
        trap_en = 1; step(); expect_take(7, "R5 kept pending");
        step();

        // R6 strict greater-than
        proc_pil = 6; pulse(6); step(); step(); expect_none("R6 equal blocked");
        proc_pil = 5; step(); expect_take(6, "R6 above pil");
        step();
        proc_pil = 12; pulse(4); step(); expect_none("R6 below blocked");
        proc_pil = 0; step(); expect_take(4, "R6 drained");
        step();

        // R7 level 15 over pil 15
        proc_pil = 15; pulse(15); step(); expect_take(15, "R7 top level");
        step(); pulse(14); step(); step(); expect_none("R7 level 14 held");
        proc_pil = 0; step(); expect_take(14, "R7 drained 14");
        step();

        // R8 synchronous trap first
        sync_trap_pend = 1; pulse(8); step(); step(); expect_none("R8 sync pending");
        sync_trap_pend = 0; step(); expect_take(8, "R8 released");
        step();

        // R3 held line
        irq_req[1] = 1; step(); step(); expect_take(2, "R3 first take");
        for (int i = 0; i < 10; i++) begin
            step(); expect_none("R3 held no repeat");
        end
        irq_req[1] = 0; step(); step(); expect_none("R3 released");

        repeat (4) step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule